// File: doc/BRIEF.md
# Link Status Monitor with Override

This block produces the link-status bit that a management status register reports. A two-bit control code, which stands for a three-level input pin, chooses the source of the bit. The two driven levels force the bit to the inverse of the driven level. The float level hands control to an internal echo check.

The echo check works as follows. Every transmit-start strobe opens a window of `WIN_CYCLES` clock cycles, which is 40 cycles (2 µs) at 20 MHz by default. Receive activity must be seen inside that window. If the window expires with no receive activity, a fail is recorded. The fail holds the bit at 0 until a management read strobe has consumed it. The read that returns 0 still reports the fail, and the bit returns to 1 on the following cycle. The management read framing, LED drive and analog level detection belong to the surrounding logic.

Top module: `link_status_monitor`

## Requirements
- R1: After reset, with the float code applied, `link_up` is 1 and no window is open.
- R2: Code 2'b00 (driven low) makes `link_up` 1, and code 2'b01 (driven high) makes it 0, in the same cycle the code is applied.
- R3: Codes 2'b10 and 2'b11 both mean float, and the echo check then drives `link_up`.
- R4: While the code is float and no transmit start has occurred, `link_up` stays 1 whatever `rx_active` and `stat_rd` do.
- R5: Receive activity sampled on any of the `WIN_CYCLES` clock edges after the edge that sampled `tx_start` closes the window, and `link_up` stays 1.
- R6: With no receive activity on those edges, `link_up` falls to 0 right after the `WIN_CYCLES`-th edge following the transmit start.
- R7: Once latched at 0, `link_up` stays 0 through later transmits and receive activity until a read strobe.
- R8: A read strobe sampled while a fail is latched sees `link_up` = 0 during its own cycle, and `link_up` is 1 from the next cycle.
- R9: A transmit start while a window is open restarts the full `WIN_CYCLES` count.
- R10: When `tx_start` and `rx_active` are high in the same cycle, the start takes priority and the receive activity does not close the new window.
- R11: If a window expires on the same edge that samples a read strobe, the fail stays latched.
- R12: Applying a driven code clears any open window and any latched fail, so returning to float shows 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ovr_code | input | 2 | Override code: 00 driven low, 01 driven high, 10/11 float |
| tx_start | input | 1 | One-cycle strobe at the start of a transmitted packet |
| rx_active | input | 1 | High while receive activity is present |
| stat_rd | input | 1 | One-cycle strobe marking a management read of the status register |
| link_up | output | 1 | Link-status bit (1 pass, 0 fail) |

## Verification
On every cycle, the assertions check the following: the window counter stays within range, a transmit start restarts it, the fail latch holds and clears only as R7, R8 and R11 allow, a driven code flushes all echo-check state, and each override level maps to its fixed output. Some behaviours can only be shown by the bench's scenarios. These are the exact expiry edge of the window, acceptance of receive activity on its last cycle, the restart after a second transmit, the start-over-receive priority, and the pass state before any transmission. The bench shows them by comparing the output against a behavioural model on every cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    OVR_DRV_LOW  = 2'b00,
    OVR_DRV_HIGH = 2'b01,
    OVR_FLOAT    = 2'b10,
    OVR_FLOAT_B  = 2'b11
  } ovr_code_e;

  // Both codes with the upper bit set select the internal echo check.
  function automatic logic code_is_float(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/lsm_rst_sync.sv
module lsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/lsm_echo_timer.sv
module lsm_echo_timer #(
  parameter int WIN_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tx_start_i,
  input  logic rx_active_i,
  output logic win_open_o,
  output logic expire_o
);

  localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             expire_c;

  always_comb begin
    open_d   = open_q;
    cnt_d    = cnt_q;
    expire_c = 1'b0;
    if (!en_i) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else if (tx_start_i) begin
      open_d = 1'b1;
      cnt_d  = '0;
    end else if (open_q) begin
      if (rx_active_i) begin
        open_d = 1'b0;
        cnt_d  = '0;
      end else if (cnt_q == LAST) begin
        open_d   = 1'b0;
        cnt_d    = '0;
        expire_c = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_ce = (cnt_d != cnt_q) || (open_d != open_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_ce) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign win_open_o = open_q;
  assign expire_o   = expire_c;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tx_start_i) |=> (open_q && cnt_q == '0));

endmodule

// File: rtl/lsm_fail_latch.sv
module lsm_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fail_i,
  input  logic rd_i,
  output logic latched_o
);

  logic latched_q, latched_d;
  logic latch_ce;

  always_comb begin
    latched_d = latched_q;
    if (!en_i)       latched_d = 1'b0;
    else if (fail_i) latched_d = 1'b1;
    else if (rd_i)   latched_d = 1'b0;
  end

  assign latch_ce = latched_d != latched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latched_q <= 1'b0;
    else if (latch_ce) latched_q <= latched_d;
  end

  assign latched_o = latched_q;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && en_i && !rd_i) |=> latched_q);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && rd_i && !fail_i) |=> !latched_q);

  // R11
  fail_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fail_i) |=> latched_q);

endmodule

// File: rtl/link_status_monitor.sv
module link_status_monitor #(
  parameter int WIN_CYCLES  = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic [1:0] ovr_code,
  input  logic       tx_start,
  input  logic       rx_active,
  input  logic       stat_rd,
  output logic       link_up
);
  import lsm_pkg::*;

  logic      rst_n;
  logic      algo_en;
  logic      win_open;
  logic      expire;
  logic      fail_latched;
  ovr_code_e code;

  lsm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign code    = ovr_code_e'(ovr_code);
  assign algo_en = code_is_float(ovr_code);

  lsm_echo_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (algo_en),
    .tx_start_i  (tx_start),
    .rx_active_i (rx_active),
    .win_open_o  (win_open),
    .expire_o    (expire)
  );

  lsm_fail_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (algo_en),
    .fail_i    (expire),
    .rd_i      (stat_rd),
    .latched_o (fail_latched)
  );

  always_comb begin
    unique case (code)
      OVR_DRV_LOW:  link_up = 1'b1;
      OVR_DRV_HIGH: link_up = 1'b0;
      default:      link_up = ~fail_latched;
    endcase
  end

  // R12
  override_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !algo_en |=> (!win_open && !fail_latched));

  // R2
  drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_code == 2'b01) |-> !link_up);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!win_open && !fail_latched));

endmodule

// File: tb/tb_link_status_monitor.sv
module tb_link_status_monitor;
  localparam int CLK_PERIOD = 50;
  localparam int WIN = 8;

  logic       clk = 1'b0;
  logic       arst_n;
  logic [1:0] ovr_code;
  logic       tx_start, rx_active, stat_rd;
  logic       link_up;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural model state
  int  m_open = 0;
  int  m_cnt  = 0;
  int  m_latch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_status_monitor #(.WIN_CYCLES(WIN), .SYNC_STAGES(2)) dut (
    .clk(clk), .arst_n(arst_n), .ovr_code(ovr_code),
    .tx_start(tx_start), .rx_active(rx_active), .stat_rd(stat_rd),
    .link_up(link_up)
  );

  always @(posedge clk) begin
    bit fail_now;
    fail_now = 0;
    if (!arst_n) begin
      m_open = 0; m_cnt = 0; m_latch = 0;
    end else if (ovr_code[1] == 1'b0) begin
      m_open = 0; m_cnt = 0; m_latch = 0;
    end else begin
      if (tx_start) begin
        m_open = 1; m_cnt = 0;
      end else if (m_open != 0) begin
        if (rx_active) m_open = 0;
        else if (m_cnt == WIN - 1) begin m_open = 0; fail_now = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (fail_now) m_latch = 1;
      else if (stat_rd) m_latch = 0;
    end
  end

  function automatic logic model_link();
    if (ovr_code == 2'b00) return 1'b1;
    if (ovr_code == 2'b01) return 1'b0;
    return (m_latch != 0) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: link_up=%b expected %b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic tx, input logic rx, input logic rd, input logic [1:0] oc);
    @(negedge clk);
    tx_start = tx; rx_active = rx; stat_rd = rd; ovr_code = oc;
    #1;
    check(link_up, model_link(), cur_req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'b10);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 20000", cyc);
      summary();
    end
  end

  initial begin
    arst_n = 0; ovr_code = 2'b10; tx_start = 0; rx_active = 0; stat_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); arst_n = 1;
    // R1: pass state after reset
    cur_req = "R1";
    idle(4);
    check(link_up, 1'b1, "R1");

    // R4: no transmit yet, receive and reads change nothing
    cur_req = "R4";
    step(0, 1, 0, 2'b10); step(0, 0, 1, 2'b10); step(0, 1, 1, 2'b10);
    idle(WIN + 2);
    check(link_up, 1'b1, "R4");

    // R5: echo early and on the last window cycle
    cur_req = "R5";
    step(1, 0, 0, 2'b10); idle(2); step(0, 1, 0, 2'b10); idle(WIN + 2);
    check(link_up, 1'b1, "R5");
    step(1, 0, 0, 2'b10); idle(WIN - 1); step(0, 1, 0, 2'b10); idle(3);
    check(link_up, 1'b1, "R5");

    // R6: expiry exactly after WIN edges
    cur_req = "R6";
    step(1, 0, 0, 2'b10);
    idle(WIN);
    check(link_up, 1'b1, "R6");
    idle(1);
    check(link_up, 1'b0, "R6");

    // R7: holds through a successful exchange
    cur_req = "R7";
    step(1, 0, 0, 2'b10); step(0, 1, 0, 2'b10); idle(3);
    check(link_up, 1'b0, "R7");

    // R8: read returns 0, pass on next cycle
    cur_req = "R8";
    step(0, 0, 1, 2'b10);
    check(link_up, 1'b0, "R8");
    idle(1);
    check(link_up, 1'b1, "R8");

    // R9: second transmit restarts the window
    cur_req = "R9";
    step(1, 0, 0, 2'b10); idle(WIN - 2); step(1, 0, 0, 2'b10); idle(WIN - 1);
    step(0, 1, 0, 2'b10); idle(2);
    check(link_up, 1'b1, "R9");
    step(1, 0, 0, 2'b10); idle(WIN - 2); step(1, 0, 0, 2'b10); idle(WIN + 1);
    check(link_up, 1'b0, "R9");
    step(0, 0, 1, 2'b10); idle(1);

    // R10: start beats simultaneous receive
    cur_req = "R10";
    step(1, 1, 0, 2'b10); idle(WIN + 1);
    check(link_up, 1'b0, "R10");
    step(0, 0, 1, 2'b10); idle(1);
    check(link_up, 1'b1, "R10");

    // R11: read on the expiry edge does not clear
    cur_req = "R11";
    step(1, 0, 0, 2'b10); idle(WIN - 1); step(0, 0, 1, 2'b10); idle(2);
    check(link_up, 1'b0, "R11");

    // R12: driven code flushes latch; R2 levels
    cur_req = "R2";
    step(0, 0, 0, 2'b00);
    check(link_up, 1'b1, "R2");
    step(0, 0, 0, 2'b01);
    check(link_up, 1'b0, "R2");
    step(1, 0, 0, 2'b01); idle(0);
    cur_req = "R12";
    step(0, 0, 0, 2'b10); idle(WIN + 2);
    check(link_up, 1'b1, "R12");

    // R3: code 11 also runs the echo check
    cur_req = "R3";
    step(1, 0, 0, 2'b11);
    for (int i = 0; i < WIN + 1; i++) step(0, 0, 0, 2'b11);
    check(link_up, 1'b0, "R3");
    step(0, 0, 1, 2'b11); step(0, 0, 0, 2'b11);
    check(link_up, 1'b1, "R3");

    // R1: reset while a window is open
    cur_req = "R1";
    step(1, 0, 0, 2'b10);
    @(negedge clk); arst_n = 0; tx_start = 0;
    @(negedge clk); arst_n = 1;
    idle(WIN + 4);
    check(link_up, 1'b1, "R1");

    summary();
  end
endmodule